// File: doc/BRIEF.md
# Ethernet Controller Control/Status Register Bank

This block is the register bank of an Ethernet controller. It holds sixty-four 16-bit registers on a word-addressed synchronous bus. The bus has one address, a write enable and write data. Read data is a combinational function of the address and the stored state.

Each register applies its own write rule. Some registers store the written value unchanged. Some keep only certain bits. Some store the inverse of the written value. Some accept writes only while the controller is in software reset. Some ignore writes entirely. The interrupt status register is write-one-to-clear.

Writes to the command register are decoded into command bits. Each accepted command bit is also reported to the other engines as a one-cycle pulse. The engines set status bits through a set vector and clear their own command bits through done inputs. They read the receive-ring pointers on dedicated outputs. A level interrupt is high whenever a masked status bit is pending.

Top module: `nic_csr_bank`

## Requirements
- R1: `irq` is high exactly when the interrupt mask register (address 4) and the interrupt status register (address 5) share a set bit. It follows the registered state, so it changes in the cycle after the write or status set that caused the change.
- R2: A write to address 5 clears only the bits that are written as 1 and are currently set. When such a write clears bit 5 (buffer exhausted), `rereadPulse` is high for the one cycle after the write.
- R3: Bit 15 of address 4 always reads 0. Writes to addresses 8, 9, 10 and 11 (ring start, ring end, read pointer, write pointer) store bit 0 as 0. These four registers are presented on `ringStart`, `ringEnd`, `rdPtr` and `wrPtr`.
- R4: Addresses 16, 17 and 18 (CRC error, alignment error and missed packet tallies) store the bitwise inverse of the written value.
- R5: A write to address 3 (transmit control) keeps only bits 15:12. A write to address 2 (receive control) keeps only bits 15:5.
- R6: Address 1 (configuration, masked with 0xBFFF) and address 31 (second configuration, masked with 0xF017) change only while command bit 7 (software reset) is set. At any other time a write to them leaves them unchanged.
- R7: Address 20 reads the revision code 0x0004 and ignores writes. Addresses 21 to 23 (match-table data ports) and address 24 (timer) ignore writes. The match-table ports read `camRdData` while command bit 7 is set and read 0 otherwise. Address 24 reads 0.
- R8: A write to address 0 while command bit 7 is set, with data that has bit 7 clear, only clears bit 7, and `cmdPulse` stays 0. Any other command write ORs `wrData & 0x03BF` into the command register. That same masked value appears on `cmdPulse` for the one cycle after the write.
- R9: The command bits are: 0 halt transmit, 1 transmit, 2 receiver off, 3 receiver on, 4 timer stop, 5 timer start, 7 software reset, 8 resource read, 9 match-table load. The following side effects apply in this order:
  - writing bit 2 clears bit 3;
  - writing bit 3 clears bit 2;
  - writing bit 4 clears bit 5;
  - writing bit 5 clears bit 4;
  - writing bit 7 clears bits 9, 8, 1 and 0 and sets bit 2.
- R10: After hardware reset:
  - address 0 reads 0x0094;
  - addresses 4 and 5 read 0;
  - address 12 (end-of-buffer count) reads 0x02F8;
  - every other stored register reads 0.
- R11: `txDone` clears command bit 1, `rsrcDone` clears bit 8 and `camDone` clears bit 9. A bit set through `statSet` is set after the edge even when the same cycle's software write clears it.
- R12: Any address without another rule here stores the full written value and reads it back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write enable for the addressed register |
| addr | input | ADDR_W | Word address for both read and write |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data of the addressed register |
| statSet | input | 16 | Status bits set by engines |
| txDone | input | 1 | Transmit engine finished; clears command bit 1 |
| rsrcDone | input | 1 | Resource read finished; clears command bit 8 |
| camDone | input | 1 | Match-table load finished; clears command bit 9 |
| camRdData | input | 16 | Match-table word presented on the data ports |
| irq | output | 1 | Level interrupt |
| cmdPulse | output | 16 | One-cycle copy of the accepted command bits |
| rereadPulse | output | 1 | Resource re-read request on clearing status bit 5 |
| ringStart | output | 16 | Ring start register |
| ringEnd | output | 16 | Ring end register |
| rdPtr | output | 16 | Ring read pointer register |
| wrPtr | output | 16 | Ring write pointer register |

## Verification
Most wrong internal state is visible on the very next read of the register concerned. A corrupted command register also shows up one cycle after the next command write, as a wrong `cmdPulse` or a missed reset exit. A status or mask register that holds a wrong value drives `irq` wrongly in the cycle after the bad update. Missing that cycle would let a spurious or lost interrupt go unseen. For this reason the bench compares every output against its reference on every clock, not only at the end of each sequence.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

  localparam int unsigned REG_W = 16;

  // register addresses
  localparam int ADR_CMD    = 0;
  localparam int ADR_CFG    = 1;
  localparam int ADR_RXCTL  = 2;
  localparam int ADR_TXCTL  = 3;
  localparam int ADR_IMASK  = 4;
  localparam int ADR_ISTAT  = 5;
  localparam int ADR_RSTART = 8;
  localparam int ADR_REND   = 9;
  localparam int ADR_RDPTR  = 10;
  localparam int ADR_WRPTR  = 11;
  localparam int ADR_EOB    = 12;
  localparam int ADR_TCRC   = 16;
  localparam int ADR_TMISS  = 18;
  localparam int ADR_REV    = 20;
  localparam int ADR_CAM0   = 21;
  localparam int ADR_CAM2   = 23;
  localparam int ADR_TIMER  = 24;
  localparam int ADR_CFG2   = 31;

  // command bit positions
  localparam int CMD_HALT   = 0;
  localparam int CMD_TX     = 1;
  localparam int CMD_RXOFF  = 2;
  localparam int CMD_RXON   = 3;
  localparam int CMD_TSTOP  = 4;
  localparam int CMD_TSTART = 5;
  localparam int CMD_RST    = 7;
  localparam int CMD_RSRC   = 8;
  localparam int CMD_CAM    = 9;

  localparam logic [REG_W-1:0] CMD_MASK = 16'h03BF;
  localparam logic [REG_W-1:0] CMD_INIT = 16'h0094;
  localparam int STAT_BUFEX = 5;

  typedef enum logic [2:0] {
    WR_PLAIN, WR_MASK, WR_INV, WR_LOCKED, WR_NONE, WR_W1C, WR_CMD
  } wrRule_e;

  typedef struct packed {
    logic             regWe;
    logic [REG_W-1:0] regVal;
    logic [REG_W-1:0] statClr;
  } csrStrobe_t;

  function automatic wrRule_e ruleOf(input int a);
    if (a == ADR_CMD) return WR_CMD;
    if (a == ADR_ISTAT) return WR_W1C;
    if (a == ADR_CFG || a == ADR_CFG2) return WR_LOCKED;
    if (a == ADR_RXCTL || a == ADR_TXCTL || a == ADR_IMASK) return WR_MASK;
    if (a >= ADR_RSTART && a <= ADR_WRPTR) return WR_MASK;
    if (a >= ADR_TCRC && a <= ADR_TMISS) return WR_INV;
    if (a >= ADR_REV && a <= ADR_TIMER) return WR_NONE;
    return WR_PLAIN;
  endfunction

  function automatic logic [REG_W-1:0] maskOf(input int a);
    if (a == ADR_CFG) return 16'hBFFF;
    if (a == ADR_CFG2) return 16'hF017;
    if (a == ADR_RXCTL) return 16'hFFE0;
    if (a == ADR_TXCTL) return 16'hF000;
    if (a == ADR_IMASK) return 16'h7FFF;
    if (a >= ADR_RSTART && a <= ADR_WRPTR) return 16'hFFFE;
    return 16'hFFFF;
  endfunction

endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [REG_W-1:0]  statQ,
  input  logic              txDone,
  input  logic              rsrcDone,
  input  logic              camDone,
  output logic [REG_W-1:0]  cmdQ,
  output logic [REG_W-1:0]  cmdPulse,
  output logic              rereadPulse,
  output csrStrobe_t        strobe
);

  wrRule_e          rule;
  logic             resetMode;
  logic             cmdWr;
  logic [REG_W-1:0] accepted;
  logic [REG_W-1:0] cmdNext;
  logic [REG_W-1:0] pulseNext;

  assign rule      = ruleOf(int'(addr));
  assign resetMode = cmdQ[CMD_RST];
  assign cmdWr     = wrEn && (rule == WR_CMD);

  // write-rule decode into strobes for the datapath
  always_comb begin
    strobe = '0;
    case (rule)
      WR_PLAIN: begin
        strobe.regWe  = wrEn;
        strobe.regVal = wrData;
      end
      WR_MASK: begin
        strobe.regWe  = wrEn;
        strobe.regVal = wrData & maskOf(int'(addr));
      end
      WR_INV: begin
        strobe.regWe  = wrEn;
        strobe.regVal = ~wrData;
      end
      WR_LOCKED: begin
        strobe.regWe  = wrEn && resetMode;
        strobe.regVal = wrData & maskOf(int'(addr));
      end
      WR_W1C: begin
        if (wrEn) strobe.statClr = wrData & statQ;
      end
      default: ;
    endcase
  end

  // command register next state
  always_comb begin
    cmdNext   = cmdQ;
    pulseNext = '0;
    accepted  = '0;
    if (txDone)   cmdNext[CMD_TX]   = 1'b0;
    if (rsrcDone) cmdNext[CMD_RSRC] = 1'b0;
    if (camDone)  cmdNext[CMD_CAM]  = 1'b0;
    if (cmdWr) begin
      if (resetMode && !wrData[CMD_RST]) begin
        cmdNext[CMD_RST] = 1'b0;
      end else begin
        accepted  = wrData & CMD_MASK;
        pulseNext = accepted;
        cmdNext   = cmdNext | accepted;
        if (accepted[CMD_RXOFF])  cmdNext[CMD_RXON]   = 1'b0;
        if (accepted[CMD_RXON])   cmdNext[CMD_RXOFF]  = 1'b0;
        if (accepted[CMD_TSTOP])  cmdNext[CMD_TSTART] = 1'b0;
        if (accepted[CMD_TSTART]) cmdNext[CMD_TSTOP]  = 1'b0;
        if (accepted[CMD_RST]) begin
          cmdNext[CMD_CAM]   = 1'b0;
          cmdNext[CMD_RSRC]  = 1'b0;
          cmdNext[CMD_TX]    = 1'b0;
          cmdNext[CMD_HALT]  = 1'b0;
          cmdNext[CMD_RXOFF] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ        <= CMD_INIT;
      cmdPulse    <= '0;
      rereadPulse <= 1'b0;
    end else begin
      cmdQ        <= cmdNext;
      cmdPulse    <= pulseNext;
      rereadPulse <= strobe.statClr[STAT_BUFEX];
    end
  end

endmodule

// File: rtl/nic_csr_data.sv
module nic_csr_data
  import nic_csr_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 6,
  parameter logic [REG_W-1:0] REV_CODE = 16'h0004,
  parameter logic [REG_W-1:0] EOB_INIT = 16'h02F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  csrStrobe_t        strobe,
  input  logic [REG_W-1:0]  statSet,
  input  logic              resetMode,
  input  logic [REG_W-1:0]  cmdQ,
  input  logic [REG_W-1:0]  camRdData,
  output logic [REG_W-1:0]  rdData,
  output logic              irq,
  output logic [REG_W-1:0]  statQ,
  output logic [REG_W-1:0]  ringStart,
  output logic [REG_W-1:0]  ringEnd,
  output logic [REG_W-1:0]  rdPtr,
  output logic [REG_W-1:0]  wrPtr
);

  localparam int unsigned NUM_REGS  = 1 << ADDR_W;
  localparam int unsigned RING_REGS = ADR_WRPTR - ADR_RSTART + 1;

  logic [REG_W-1:0] regQ [NUM_REGS];
  logic [REG_W-1:0] ringQ [RING_REGS];

  function automatic logic [REG_W-1:0] initOf(input int i);
    return (i == ADR_EOB) ? EOB_INIT : '0;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= initOf(i);
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (i == ADR_ISTAT) begin
          // engine sets win over a same-cycle software clear
          regQ[i] <= (regQ[i] & ~strobe.statClr) | statSet;
        end else if (strobe.regWe && (addr == ADDR_W'(i))) begin
          regQ[i] <= strobe.regVal;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < RING_REGS; g++) begin : g_ring
      assign ringQ[g] = regQ[ADR_RSTART + g];
    end
  endgenerate

  assign ringStart = ringQ[0];
  assign ringEnd   = ringQ[1];
  assign rdPtr     = ringQ[2];
  assign wrPtr     = ringQ[3];
  assign statQ     = regQ[ADR_ISTAT];
  assign irq       = |(regQ[ADR_IMASK] & regQ[ADR_ISTAT]);

  always_comb begin
    if (int'(addr) == ADR_CMD) begin
      rdData = cmdQ;
    end else if (int'(addr) == ADR_REV) begin
      rdData = REV_CODE;
    end else if (int'(addr) >= ADR_CAM0 && int'(addr) <= ADR_CAM2) begin
      rdData = resetMode ? camRdData : '0;
    end else if (int'(addr) == ADR_TIMER) begin
      rdData = '0;
    end else begin
      rdData = regQ[addr];
    end
  end

endmodule

// File: rtl/nic_csr_bank.sv
module nic_csr_bank
  import nic_csr_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 6,
  parameter logic [REG_W-1:0] REV_CODE = 16'h0004,
  parameter logic [REG_W-1:0] EOB_INIT = 16'h02F8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [15:0]       statSet,
  input  logic              txDone,
  input  logic              rsrcDone,
  input  logic              camDone,
  input  logic [15:0]       camRdData,
  output logic              irq,
  output logic [15:0]       cmdPulse,
  output logic              rereadPulse,
  output logic [15:0]       ringStart,
  output logic [15:0]       ringEnd,
  output logic [15:0]       rdPtr,
  output logic [15:0]       wrPtr
);

  csrStrobe_t       strobe;
  logic [REG_W-1:0] cmdQ;
  logic [REG_W-1:0] statQ;

  nic_csr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .statQ(statQ), .txDone(txDone), .rsrcDone(rsrcDone), .camDone(camDone),
    .cmdQ(cmdQ), .cmdPulse(cmdPulse), .rereadPulse(rereadPulse),
    .strobe(strobe)
  );

  nic_csr_data #(.ADDR_W(ADDR_W), .REV_CODE(REV_CODE), .EOB_INIT(EOB_INIT)) u_data (
    .clk(clk), .rstN(rstN), .addr(addr), .strobe(strobe), .statSet(statSet),
    .resetMode(cmdQ[CMD_RST]), .cmdQ(cmdQ), .camRdData(camRdData),
    .rdData(rdData), .irq(irq), .statQ(statQ), .ringStart(ringStart),
    .ringEnd(ringEnd), .rdPtr(rdPtr), .wrPtr(wrPtr)
  );

endmodule

// File: rtl/nic_csr_checker.sv
module nic_csr_checker
  import nic_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wrData,
  input logic [15:0]       rdData,
  input logic [15:0]       statSet,
  input logic              txDone,
  input logic              rsrcDone,
  input logic              camDone,
  input logic              irq,
  input logic [15:0]       cmdPulse,
  input logic [15:0]       cmdQ,
  input logic [15:0]       statQ
);

  logic atCmd, atStat, atMask, atCfg;
  assign atCmd  = (addr == ADDR_W'(ADR_CMD));
  assign atStat = (addr == ADDR_W'(ADR_ISTAT));
  assign atMask = (addr == ADDR_W'(ADR_IMASK));
  assign atCfg  = (addr == ADDR_W'(ADR_CFG));

  // R1: a zero mask silences the interrupt on the next cycle
  p_irq_masked_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atMask && wrData == 16'h0) |=> !irq);

  // R2: written ones leave no set bit behind when no engine sets
  p_w1c_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atStat && statSet == 16'h0) |=> ((statQ & $past(wrData)) == 16'h0));

  // R11: engine status sets always land
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (statSet != 16'h0) |=> ((statQ & $past(statSet)) == $past(statSet)));

  // R8: reset exit clears only the reset bit
  p_reset_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atCmd && cmdQ[CMD_RST] && !wrData[CMD_RST] && !txDone && !rsrcDone && !camDone)
    |=> (cmdQ == ($past(cmdQ) & ~16'h0080)) && (cmdPulse == 16'h0));

  // R8: pulses only follow a command write
  p_pulse_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPulse != 16'h0) |-> $past(wrEn && atCmd));

  // R6: configuration is frozen outside reset mode
  p_cfg_lock_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && atCfg && !cmdQ[CMD_RST]) |=> (!atCfg || rdData == $past(rdData)));

endmodule

bind nic_csr_bank nic_csr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .statSet(statSet), .txDone(txDone), .rsrcDone(rsrcDone),
  .camDone(camDone), .irq(irq), .cmdPulse(cmdPulse), .cmdQ(cmdQ), .statQ(statQ)
);

// File: tb/sim_nic_csr_bank.sv
module sim_nic_csr_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [15:0] statSet = '0;
  logic        txDone = 1'b0, rsrcDone = 1'b0, camDone = 1'b0;
  logic [15:0] camRdData = '0;
  logic        irq;
  logic [15:0] cmdPulse;
  logic        rereadPulse;
  logic [15:0] ringStart, ringEnd, rdPtr, wrPtr;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [15:0] mReg [64];
  logic [15:0] mCmd;
  logic [15:0] mPulse;
  logic        mReread;

  always #10 clk = ~clk;

  nic_csr_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .statSet(statSet), .txDone(txDone), .rsrcDone(rsrcDone),
    .camDone(camDone), .camRdData(camRdData), .irq(irq), .cmdPulse(cmdPulse),
    .rereadPulse(rereadPulse), .ringStart(ringStart), .ringEnd(ringEnd),
    .rdPtr(rdPtr), .wrPtr(wrPtr)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] modelRead(input int a);
    if (a == 0) return mCmd;
    if (a == 20) return 16'h0004;
    if (a >= 21 && a <= 23) return mCmd[7] ? camRdData : 16'h0;
    if (a == 24) return 16'h0;
    return mReg[a];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 64; i++) mReg[i] = 16'h0;
    mReg[12] = 16'h02F8;
    mCmd = 16'h0094;
    mPulse = 16'h0;
    mReread = 1'b0;
  endtask

  task automatic modelEdge(input logic we, input int a, input logic [15:0] d,
                           input logic [15:0] set, input logic tx, input logic rs,
                           input logic cm);
    logic [15:0] clr, nStat, nCmd, acc;
    clr = (we && a == 5) ? (d & mReg[5]) : 16'h0;
    mReread = clr[5];
    nStat = (mReg[5] & ~clr) | set;
    nCmd = mCmd;
    if (tx) nCmd[1] = 1'b0;
    if (rs) nCmd[8] = 1'b0;
    if (cm) nCmd[9] = 1'b0;
    mPulse = 16'h0;
    if (we && a == 0) begin
      if (mCmd[7] && !d[7]) nCmd[7] = 1'b0;
      else begin
        acc = d & 16'h03BF;
        mPulse = acc;
        nCmd = nCmd | acc;
        if (acc[2]) nCmd[3] = 1'b0;
        if (acc[3]) nCmd[2] = 1'b0;
        if (acc[4]) nCmd[5] = 1'b0;
        if (acc[5]) nCmd[4] = 1'b0;
        if (acc[7]) begin
          nCmd = nCmd & ~16'h0303;
          nCmd[2] = 1'b1;
        end
      end
    end else if (we) begin
      case (a)
        1:  if (mCmd[7]) mReg[1] = d & 16'hBFFF;
        31: if (mCmd[7]) mReg[31] = d & 16'hF017;
        2:  mReg[2] = d & 16'hFFE0;
        3:  mReg[3] = d & 16'hF000;
        4:  mReg[4] = d & 16'h7FFF;
        8, 9, 10, 11: mReg[a] = d & 16'hFFFE;
        16, 17, 18: mReg[a] = ~d;
        5, 20, 21, 22, 23, 24: ;
        default: mReg[a] = d;
      endcase
    end
    mCmd = nCmd;
    mReg[5] = nStat;
  endtask

  // one clock: drive, let the edge happen, compare every output
  task automatic step(input logic we, input int a, input logic [15:0] d,
                      input string tag = "R12", input logic [15:0] set = 16'h0,
                      input logic tx = 1'b0, input logic rs = 1'b0, input logic cm = 1'b0);
    wrEn = we; addr = 6'(a); wrData = d; statSet = set;
    txDone = tx; rsrcDone = rs; camDone = cm;
    @(posedge clk);
    modelEdge(we, a, d, set, tx, rs, cm);
    @(negedge clk);
    check(tag, rdData, modelRead(a));
    check("R1 irq", {15'h0, irq}, {15'h0, |(mReg[4] & mReg[5])});
    check("R8 cmdPulse", cmdPulse, mPulse);
    check("R2 rereadPulse", {15'h0, rereadPulse}, {15'h0, mReread});
    check("R3 ring ports", ringStart ^ ringEnd ^ rdPtr ^ wrPtr,
          mReg[8] ^ mReg[9] ^ mReg[10] ^ mReg[11]);
    check("R3 rdPtr", rdPtr, mReg[10]);
  endtask

  task automatic rd(input int a, input string tag);
    step(1'b0, a, 16'h0, tag);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    rd(0, "R10 cmd reset");
    rd(4, "R10 mask reset");
    rd(5, "R10 status reset");
    rd(12, "R10 eob reset");
    rd(40, "R10 plain reset");
    check("R10 direct cmd", rdData, 16'h0);  // address 40 reads zero
    rd(20, "R7 revision");

    // R6 configuration writes in reset mode
    step(1'b1, 1, 16'hFFFF, "R6 cfg in reset");
    step(1'b1, 31, 16'hFFFF, "R6 cfg2 in reset");
    rd(1, "R6 cfg mask");
    check("R6 cfg value", rdData, 16'hBFFF);
    rd(31, "R6 cfg2 mask");
    check("R6 cfg2 value", rdData, 16'hF017);

    // R7 read-only and match-table ports
    camRdData = 16'h1234;
    rd(22, "R7 cam port in reset");
    check("R7 cam value", rdData, 16'h1234);
    step(1'b1, 20, 16'hFFFF, "R7 revision write");
    check("R7 revision kept", rdData, 16'h0004);
    step(1'b1, 24, 16'hFFFF, "R7 timer write");
    rd(24, "R7 timer read");
    check("R7 timer zero", rdData, 16'h0000);

    // R8 reset exit
    step(1'b1, 0, 16'h0000, "R8 reset exit");
    check("R8 cmd after exit", rdData, 16'h0014);
    check("R8 no pulse on exit", cmdPulse, 16'h0000);
    rd(21, "R7 cam port outside reset");
    check("R7 cam zero", rdData, 16'h0000);
    step(1'b1, 1, 16'h0000, "R6 cfg locked");
    rd(1, "R6 cfg unchanged");
    check("R6 cfg still", rdData, 16'hBFFF);
    step(1'b1, 31, 16'h0000, "R6 cfg2 locked");

    // R9 paired commands
    step(1'b1, 0, 16'h0008, "R9 rx on");
    check("R9 rx on value", rdData, 16'h0018);
    step(1'b1, 0, 16'h0020, "R9 timer start");
    check("R9 timer start value", rdData, 16'h0028);
    step(1'b1, 0, 16'h0003, "R8 tx and halt");
    check("R8 pulse tx", cmdPulse, 16'h0003);
    step(1'b1, 0, 16'hFC40, "R8 masked bits");
    check("R8 masked none", cmdPulse, 16'h0000);
    step(1'b1, 0, 16'h000C, "R9 both rx");
    step(1'b1, 0, 16'h0030, "R9 both timer");

    // R11 done inputs
    step(1'b0, 0, 16'h0, "R11 tx done", 16'h0, 1'b1);
    step(1'b1, 0, 16'h0300, "R11 load and read");
    step(1'b0, 0, 16'h0, "R11 engines done", 16'h0, 1'b0, 1'b1, 1'b1);
    step(1'b1, 0, 16'h0302, "R9 set before reset");
    step(1'b1, 0, 16'h0080, "R9 software reset");
    step(1'b1, 0, 16'h0000, "R8 second exit");

    // R3 mask, R1 irq, R2 clear
    step(1'b1, 4, 16'hFFFF, "R3 mask write");
    check("R3 mask bit15", rdData, 16'h7FFF);
    step(1'b0, 5, 16'h0, "R1 status set", 16'h0080);
    check("R1 irq high", {15'h0, irq}, 16'h0001);
    step(1'b0, 5, 16'h0, "R2 bufex set", 16'h0020);
    step(1'b1, 5, 16'h0020, "R2 clear bufex");
    check("R2 reread pulse", {15'h0, rereadPulse}, 16'h0001);
    step(1'b1, 5, 16'h0020, "R2 clear again");
    check("R2 no second pulse", {15'h0, rereadPulse}, 16'h0000);
    step(1'b1, 5, 16'hFFFF, "R11 set beats clear", 16'h0080);
    check("R11 status kept", rdData, 16'h0080);
    step(1'b1, 4, 16'h0000, "R1 mask off");
    check("R1 irq low", {15'h0, irq}, 16'h0000);

    // R3 ring registers
    for (int i = 8; i < 12; i++) step(1'b1, i, 16'h1001 + 16'(i), "R3 ring write");
    check("R3 ring start", ringStart, 16'h1008);
    check("R3 ring end", ringEnd, 16'h100A);

    // R4 tallies, R5 controls, R12 plain
    for (int i = 16; i < 19; i++) step(1'b1, i, 16'h1234, "R4 tally inverse");
    check("R4 tally value", rdData, 16'hEDCB);
    step(1'b1, 3, 16'hFFFF, "R5 tx control");
    check("R5 tx value", rdData, 16'hF000);
    step(1'b1, 2, 16'hFFFF, "R5 rx control");
    check("R5 rx value", rdData, 16'hFFE0);
    step(1'b1, 40, 16'hA5A5, "R12 plain write");
    check("R12 plain value", rdData, 16'hA5A5);
    step(1'b1, 63, 16'h5A5A, "R12 top address");
    step(1'b1, 12, 16'h0100, "R12 eob write");

    // mixed traffic against the reference model
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      camRdData = lfsr[31:16] ^ 16'h5555;
      step(lfsr[6], int'(lfsr[5:0]), lfsr[31:16], "R12 mixed",
           (lfsr[12:10] == 3'b000) ? (16'h1 << lfsr[15:12]) : 16'h0,
           lfsr[7] & lfsr[8], lfsr[8] & lfsr[9], lfsr[9] & lfsr[7]);
    end

    finishRun();
  end

endmodule